// File: doc/BRIEF.md
# I2C Slave Receiver with 10-bit Addressing

This block is the receive side of an I2C slave that runs entirely on a fast system clock. The bus lines enter through synchronisers, and the block finds START, repeated START and STOP from the synchronised edges. It shifts in bytes MSB first on rising SCL. At the end of each address byte it compares the byte with a host-written address register, in either 7-bit or 10-bit mode, and pulls SDA low in the acknowledge slot when it accepts a byte. Both bus pins are open-drain: the block can only pull a line low or release it.

In 10-bit mode the address arrives as two bytes. The address register first holds the high pattern `11110 A9 A8 0`. After each accepted address byte the block raises an update-address flag and stretches SCL low. The host then writes the address register: the low address byte after the first byte, and the high pattern again after the second. That write drops the flag and frees SCL. A later repeated START that carries the high pattern with R/W=1 is accepted only after a matched 10-bit write.

Accepted bytes go to a one-entry receive buffer. The buffer is presented on a valid/ready output. `rx_valid_o` is high while an unread byte is waiting, and one transfer happens on every clock edge where valid and ready are both high. Back-pressure works as follows: while the byte is not taken, the buffer keeps it, and any further byte is refused on the bus (NACK) and recorded as an overflow. A sticky interrupt flag marks every byte of an addressed transfer.

Top module: `i2c_addr10_slave`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `irq_o`, `ovf_o`, `buf_full_o`, `rx_valid_o`, `upd_addr_o`, `start_o` and `stop_o` are all 0.
- R2: A falling SDA while SCL is high (START or repeated START) sets `start_o` and clears `stop_o`. A rising SDA while SCL is high (STOP) sets `stop_o` and clears `start_o`.
- R3: With `mode10_i`=0, the first byte after a START matches when its bits 7:1 equal address register bits 7:1. If the buffer is empty and no overflow is pending, the block acknowledges (SDA low in the ninth clock), loads the address byte into the buffer, sets `buf_full_o`, and copies byte bit 0 into `rw_o`.
- R4: A first byte that does not match gets no acknowledge and no interrupt. All bytes up to the next START or repeated START are then ignored, with no acknowledge and no buffer load.
- R5: Each byte that follows an accepted write address is loaded and acknowledged when the buffer is empty and no overflow is pending.
- R6: `irq_o` is set on the falling edge of the ninth SCL pulse of every byte of an addressed transfer, acknowledged or not. It stays set until `irq_clr_i` is pulsed.
- R7: A byte that completes while `buf_full_o`=1 is not acknowledged, leaves the buffer unchanged, and sets `ovf_o`. While `ovf_o`=1, bytes are refused even with an empty buffer. `ovf_o` stays set until `ovf_clr_i` is pulsed.
- R8: `rx_valid_o` is high when `buf_full_o`=1 and no read is pending, and `rx_data_o` holds still while it waits. A valid/ready transfer outside the acknowledge slot clears `buf_full_o` at once. A transfer inside the acknowledge slot drops `rx_valid_o` at once, but `buf_full_o` stays 1 until the ninth SCL falls.
- R9: With `mode10_i`=1, a first byte with R/W=0 matches only when its top five bits are `11110` and bits 7:1 equal address register bits 7:1. When accepted, `upd_addr_o` and `scl_oe_o` go high after the ninth SCL falls.
- R10: In 10-bit mode the second address byte must equal all eight address register bits. On a match it is acknowledged and SCL is held as in R9. On a mismatch there is no acknowledge, no interrupt and no hold.
- R11: After a matched 10-bit write, a repeated START followed by the high pattern with R/W=1 is acknowledged and sets `buf_full_o`, `irq_o` and `rw_o`=1, with no SCL hold. Without a prior matched 10-bit write, that byte is refused.
- R12: A pulse on `addr_we_i` clears `upd_addr_o` and releases `scl_oe_o` on the next clock edge, and it takes priority over a hold that starts in the same cycle.
- R13: `sda_oe_o` and `scl_oe_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level (resolved wire) |
| sda_i | input | 1 | SDA line level (resolved wire) |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| mode10_i | input | 1 | 1 selects 10-bit addressing |
| addr_we_i | input | 1 | Address register write strobe |
| addr_wdata_i | input | 8 | Address register write data |
| rx_data_o | output | 8 | Receive buffer contents |
| rx_valid_o | output | 1 | Unread byte waiting |
| rx_ready_i | input | 1 | Host takes the byte |
| buf_full_o | output | 1 | Buffer-full status |
| irq_o | output | 1 | Per-byte interrupt flag |
| irq_clr_i | input | 1 | Clears irq_o |
| ovf_o | output | 1 | Overflow flag |
| ovf_clr_i | input | 1 | Clears ovf_o |
| upd_addr_o | output | 1 | Host must rewrite the address register |
| rw_o | output | 1 | R/W bit of the last matched address |
| start_o | output | 1 | Last bus event was START |
| stop_o | output | 1 | Last bus event was STOP |

## Verification
The properties assume a well-behaved master. It changes SDA only while SCL is low, and it keeps each line level for longer than the synchroniser latency, so every edge is seen once and in the right order with respect to the other line. They also assume that host strobes are single-cycle pulses and that the address register is rewritten only during a clock stretch or while the bus is idle. The stimulus keeps within these limits: the master tasks use quarter periods of several system clocks, wait for SCL to read high before they time the high phase, and drive every pin on the falling system clock edge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);
  localparam logic [4:0] TENBIT_TAG = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_DATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2cs_rxbuf.sv
module i2cs_rxbuf import i2cs_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  input  logic              in_ack_i,
  input  logic              settle_i,
  input  logic              ready_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              full_o
);
  logic [BYTE_W-1:0] buf_q;
  logic              full_q;
  logic              pend_q;
  logic              take;

  assign valid_o = full_q & ~pend_q;
  assign take    = valid_o & ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (load_i) begin
      buf_q  <= load_data_i;
      full_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (take && !in_ack_i) full_q <= 1'b0;
      else if (take)         pend_q <= 1'b1;
      if (settle_i && pend_q) begin
        full_q <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  assign data_o = buf_q;
  assign full_o = full_q;
endmodule

// File: rtl/i2cs_core.sv
module i2cs_core import i2cs_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic              mode10_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic              addr_we_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  input  logic              buf_full_i,
  output logic              load_o,
  output logic [BYTE_W-1:0] load_data_o,
  output logic              in_ack_o,
  output logic              settle_o,
  output logic              sda_oe_o,
  output logic              hold_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              rw_o,
  output logic              start_o,
  output logic              stop_o
);
  phase_t            phase_q, nxt_q, nxt_phase;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic sda_oe_q, hold_q, irq_q, ovf_q, rw_q, sta_q, sto_q;
  logic ten_ok_q, irq_arm_q, hold_arm_q;
  logic hit, want_hold, blocked, give_ack;
  logic active, start_ev, stop_ev, bit_ev, byte_end, slot_end;

  assign start_ev = scl_lvl_i & sda_fall_i;
  assign stop_ev  = scl_lvl_i & sda_rise_i;
  assign active   = (phase_q == PH_ADDR_HI) || (phase_q == PH_ADDR_LO) ||
                    (phase_q == PH_DATA);
  assign bit_ev   = active && scl_rise_i && (cnt_q < BIT_LAST);
  assign byte_end = active && scl_fall_i && (cnt_q == BIT_LAST);
  assign slot_end = active && scl_fall_i && (cnt_q == ACK_SLOT);

  // Decision taken when the eighth bit has been shifted in
  always_comb begin
    hit       = 1'b0;
    want_hold = 1'b0;
    nxt_phase = PH_SKIP;
    unique case (phase_q)
      PH_ADDR_HI: begin
        if (!mode10_i) begin
          hit       = (sh_q[7:1] == addr_i[7:1]);
          nxt_phase = sh_q[0] ? PH_SKIP : PH_DATA;
        end else begin
          hit       = (sh_q[7:3] == TENBIT_TAG) && (sh_q[7:1] == addr_i[7:1]) &&
                      (!sh_q[0] || ten_ok_q);
          nxt_phase = sh_q[0] ? PH_SKIP : PH_ADDR_LO;
          want_hold = !sh_q[0];
        end
      end
      PH_ADDR_LO: begin
        hit       = (sh_q == addr_i);
        nxt_phase = PH_DATA;
        want_hold = 1'b1;
      end
      PH_DATA: begin
        hit       = 1'b1;
        nxt_phase = PH_DATA;
      end
      default: hit = 1'b0;
    endcase
  end

  assign blocked  = buf_full_i | ovf_q;
  assign give_ack = hit & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      nxt_q      <= PH_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      sda_oe_q   <= 1'b0;
      hold_q     <= 1'b0;
      irq_q      <= 1'b0;
      ovf_q      <= 1'b0;
      rw_q       <= 1'b0;
      sta_q      <= 1'b0;
      sto_q      <= 1'b0;
      ten_ok_q   <= 1'b0;
      irq_arm_q  <= 1'b0;
      hold_arm_q <= 1'b0;
    end else begin
      if (irq_clr_i) irq_q  <= 1'b0;
      if (ovf_clr_i) ovf_q  <= 1'b0;
      if (addr_we_i) hold_q <= 1'b0;
      if (start_ev) begin
        phase_q    <= PH_ADDR_HI;
        cnt_q      <= '0;
        sda_oe_q   <= 1'b0;
        sta_q      <= 1'b1;
        sto_q      <= 1'b0;
        irq_arm_q  <= 1'b0;
        hold_arm_q <= 1'b0;
      end else if (stop_ev) begin
        phase_q    <= PH_IDLE;
        cnt_q      <= '0;
        sda_oe_q   <= 1'b0;
        sta_q      <= 1'b0;
        sto_q      <= 1'b1;
        ten_ok_q   <= 1'b0;
        irq_arm_q  <= 1'b0;
        hold_arm_q <= 1'b0;
      end else if (bit_ev) begin
        sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl_i};
        cnt_q <= cnt_q + 1'b1;
      end else if (byte_end) begin
        cnt_q      <= ACK_SLOT;
        irq_arm_q  <= hit;
        hold_arm_q <= give_ack & want_hold;
        sda_oe_q   <= give_ack;
        if (hit && buf_full_i) ovf_q <= 1'b1;
        if (hit && phase_q == PH_ADDR_HI) rw_q <= sh_q[0];
        if (give_ack && phase_q == PH_ADDR_LO) ten_ok_q <= 1'b1;
        nxt_q <= (give_ack || phase_q == PH_DATA) ? nxt_phase : PH_SKIP;
      end else if (slot_end) begin
        cnt_q      <= '0;
        sda_oe_q   <= 1'b0;
        phase_q    <= nxt_q;
        if (irq_arm_q) irq_q <= 1'b1;
        if (hold_arm_q && !addr_we_i) hold_q <= 1'b1;
        irq_arm_q  <= 1'b0;
        hold_arm_q <= 1'b0;
      end
    end
  end

  assign load_o      = byte_end & give_ack;
  assign load_data_o = sh_q;
  assign in_ack_o    = active && (cnt_q == ACK_SLOT);
  assign settle_o    = slot_end | stop_ev;
  assign sda_oe_o    = sda_oe_q;
  assign hold_o      = hold_q;
  assign irq_o       = irq_q;
  assign ovf_o       = ovf_q;
  assign rw_o        = rw_q;
  assign start_o     = sta_q;
  assign stop_o      = sto_q;
endmodule

// File: rtl/i2c_addr10_slave.sv
module i2c_addr10_slave import i2cs_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              mode10_i,
  input  logic              addr_we_i,
  input  logic [BYTE_W-1:0] addr_wdata_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              buf_full_o,
  output logic              irq_o,
  input  logic              irq_clr_i,
  output logic              ovf_o,
  input  logic              ovf_clr_i,
  output logic              upd_addr_o,
  output logic              rw_o,
  output logic              start_o,
  output logic              stop_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, lvl, rise, fall;
  logic [BYTE_W-1:0] addr_q;
  logic [BYTE_W-1:0] load_data;
  logic load, in_ack, settle, hold;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw[g]),
      .level_o(lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (addr_we_i) addr_q <= addr_wdata_i;
  end

  i2cs_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl_i  (lvl[0]),
    .scl_rise_i (rise[0]),
    .scl_fall_i (fall[0]),
    .sda_lvl_i  (lvl[1]),
    .sda_rise_i (rise[1]),
    .sda_fall_i (fall[1]),
    .mode10_i   (mode10_i),
    .addr_i     (addr_q),
    .addr_we_i  (addr_we_i),
    .irq_clr_i  (irq_clr_i),
    .ovf_clr_i  (ovf_clr_i),
    .buf_full_i (buf_full_o),
    .load_o     (load),
    .load_data_o(load_data),
    .in_ack_o   (in_ack),
    .settle_o   (settle),
    .sda_oe_o   (sda_oe_o),
    .hold_o     (hold),
    .irq_o      (irq_o),
    .ovf_o      (ovf_o),
    .rw_o       (rw_o),
    .start_o    (start_o),
    .stop_o     (stop_o)
  );

  i2cs_rxbuf u_rxbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_data_i(load_data),
    .in_ack_i   (in_ack),
    .settle_i   (settle),
    .ready_i    (rx_ready_i),
    .data_o     (rx_data_o),
    .valid_o    (rx_valid_o),
    .full_o     (buf_full_o)
  );

  assign scl_oe_o   = hold;
  assign upd_addr_o = hold;
endmodule

// File: rtl/i2cs_props.sv
module i2cs_props (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       addr_we_i,
  input logic [7:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input logic       buf_full_o,
  input logic       irq_o,
  input logic       irq_clr_i,
  input logic       ovf_o,
  input logic       ovf_clr_i,
  input logic       upd_addr_o
);
  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !irq_clr_i |=> irq_o);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(buf_full_o));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rx_ready_i |=> $stable(rx_data_o));

  // R8
  valid_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> buf_full_o);

  // R12
  addr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we_i |=> !upd_addr_o && !scl_oe_o);

  // R13
  lines_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_oe_o && scl_oe_o));
endmodule

bind i2c_addr10_slave i2cs_props u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o),
  .addr_we_i (addr_we_i),
  .rx_data_o (rx_data_o),
  .rx_valid_o(rx_valid_o),
  .rx_ready_i(rx_ready_i),
  .buf_full_o(buf_full_o),
  .irq_o     (irq_o),
  .irq_clr_i (irq_clr_i),
  .ovf_o     (ovf_o),
  .ovf_clr_i (ovf_clr_i),
  .upd_addr_o(upd_addr_o)
);

// File: tb/i2c_addr10_slave_test.sv
`timescale 1ns/1ps
module i2c_addr10_slave_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, scl_w, sda_w;
  logic mode10 = 1'b0, addr_we = 1'b0, rx_ready = 1'b0;
  logic irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] addr_wdata = 8'h00;
  logic [7:0] rx_data;
  logic rx_valid, buf_full, irq, ovf, upd_addr, rw, start_s, stop_s;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign scl_w = m_scl & ~scl_oe;
  assign sda_w = m_sda & ~sda_oe;

  i2c_addr10_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .mode10_i(mode10),
    .addr_we_i(addr_we), .addr_wdata_i(addr_wdata),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .buf_full_o(buf_full), .irq_o(irq), .irq_clr_i(irq_clr),
    .ovf_o(ovf), .ovf_clr_i(ovf_clr), .upd_addr_o(upd_addr),
    .rw_o(rw), .start_o(start_s), .stop_o(stop_s)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    while (!scl_w) @(negedge clk);
  endtask

  task automatic bus_start();
    wait_n(Q); m_sda = 1'b1; wait_n(Q);
    scl_high(); wait_n(2*Q);
    m_sda = 1'b0; wait_n(2*Q);
    m_scl = 1'b0; wait_n(4);
  endtask

  task automatic bus_stop();
    wait_n(Q); m_sda = 1'b0; wait_n(Q);
    scl_high(); wait_n(2*Q);
    m_sda = 1'b1; wait_n(2*Q);
  endtask

  task automatic send8(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      wait_n(Q); m_sda = d[i]; wait_n(Q);
      scl_high(); wait_n(2*Q);
      m_scl = 1'b0;
    end
  endtask

  task automatic ack_bit(output logic a);
    wait_n(Q); m_sda = 1'b1; wait_n(Q);
    scl_high(); wait_n(Q);
    a = sda_w; wait_n(Q);
    m_scl = 1'b0; wait_n(8);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic a);
    send8(d);
    ack_bit(a);
  endtask

  task automatic pulse_addr(input logic [7:0] v);
    @(negedge clk); addr_we = 1'b1; addr_wdata = v;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
  endtask

  task automatic sw_read(output logic [7:0] d);
    d = rx_data;
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 scl_oe", scl_oe, 0);   chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq, 0);         chk("R1 ovf", ovf, 0);
    chk("R1 full", buf_full, 0);   chk("R1 valid", rx_valid, 0);
    chk("R1 upd", upd_addr, 0);    chk("R1 start", start_s, 0);
    chk("R1 stop", stop_s, 0);
  endtask

  task automatic t_seven_bit();
    logic a; logic [7:0] d;
    mode10 = 1'b0;
    pulse_addr(8'h84);
    bus_start();
    chk("R2 start set", start_s, 1); chk("R2 stop clr", stop_s, 0);
    send_byte(8'h84, a);
    chk("R3 ack", a, 0);            chk("R3 full", buf_full, 1);
    chk("R3 data", rx_data, 8'h84); chk("R3 rw", rw, 0);
    chk("R6 irq", irq, 1);          chk("R8 valid", rx_valid, 1);
    sw_read(d); wait_n(1);
    chk("R8 full clr", buf_full, 0); chk("R8 valid clr", rx_valid, 0);
    wait_n(20);
    chk("R6 sticky", irq, 1);
    pulse_irq_clr(); wait_n(1);
    chk("R6 cleared", irq, 0);
    send_byte(8'hA5, a);
    chk("R5 ack", a, 0); chk("R5 data", rx_data, 8'hA5); chk("R6 data irq", irq, 1);
    sw_read(d); pulse_irq_clr();
    bus_stop();
    chk("R2 stop set", stop_s, 1); chk("R2 start clr", start_s, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte(8'h86, a);
    chk("R4 nack addr", a, 1); chk("R4 no irq", irq, 0); chk("R4 no load", buf_full, 0);
    send_byte(8'h11, a);
    chk("R4 nack data", a, 1); chk("R4 still empty", buf_full, 0);
    bus_stop();
  endtask

  task automatic t_overflow();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'h84, a);
    chk("R3 ack ovf run", a, 0);
    send_byte(8'h3C, a);
    chk("R7 nack full", a, 1); chk("R7 ovf", ovf, 1);
    chk("R7 buf kept", rx_data, 8'h84); chk("R6 irq nack", irq, 1);
    sw_read(d); pulse_irq_clr(); wait_n(1);
    chk("R8 read empties", buf_full, 0);
    send_byte(8'h77, a);
    chk("R7 nack ovf", a, 1); chk("R7 empty kept", buf_full, 0); chk("R7 ovf kept", ovf, 1);
    pulse_ovf_clr(); wait_n(1);
    chk("R7 ovf clr", ovf, 0);
    send_byte(8'h99, a);
    chk("R5 ack after clr", a, 0); chk("R5 data after clr", rx_data, 8'h99);
    sw_read(d); pulse_irq_clr();
    bus_stop();
  endtask

  task automatic t_deferred();
    logic a; logic [7:0] d;
    bus_start();
    send8(8'h84); wait_n(6);
    chk("R8 in slot full", buf_full, 1); chk("R8 in slot valid", rx_valid, 1);
    chk("R13 ack only", scl_oe, 0);
    sw_read(d); wait_n(1);
    chk("R8 valid drops", rx_valid, 0); chk("R8 full held", buf_full, 1);
    ack_bit(a);
    chk("R3 ack deferred", a, 0); chk("R8 full after slot", buf_full, 0);
    send_byte(8'h5E, a);
    chk("R5 ack next", a, 0); chk("R5 data next", rx_data, 8'h5E);
    sw_read(d); pulse_irq_clr();
    bus_stop();
  endtask

  task automatic t_ten_bit();
    logic a; logic [7:0] d;
    mode10 = 1'b1;
    pulse_addr(8'hF2);
    bus_start();
    send_byte(8'hF2, a);
    chk("R9 ack hi", a, 0); chk("R9 upd", upd_addr, 1); chk("R9 hold", scl_oe, 1);
    chk("R13 sda free", sda_oe, 0); chk("R6 irq hi", irq, 1);
    sw_read(d);
    chk("R9 data hi", d, 8'hF2);
    pulse_irq_clr();
    pulse_addr(8'hC3); wait_n(1);
    chk("R12 upd clr", upd_addr, 0); chk("R12 released", scl_oe, 0);
    send_byte(8'hC3, a);
    chk("R10 ack lo", a, 0); chk("R10 upd", upd_addr, 1); chk("R10 hold", scl_oe, 1);
    chk("R10 data lo", rx_data, 8'hC3);
    sw_read(d); pulse_irq_clr();
    pulse_addr(8'hF2); wait_n(1);
    chk("R12 released lo", scl_oe, 0);
    send_byte(8'h5A, a);
    chk("R5 ack 10b", a, 0); chk("R5 data 10b", rx_data, 8'h5A); chk("R5 no hold", scl_oe, 0);
    sw_read(d); pulse_irq_clr();
    bus_start();
    chk("R2 restart", start_s, 1);
    send_byte(8'hF3, a);
    chk("R11 ack rd", a, 0); chk("R11 rw", rw, 1); chk("R11 irq", irq, 1);
    chk("R11 full", buf_full, 1); chk("R11 no hold", scl_oe, 0);
    bus_stop();
    sw_read(d); pulse_irq_clr();
  endtask

  task automatic t_ten_bit_bad();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'hF3, a);
    chk("R11 rd refused", a, 1); chk("R11 no irq", irq, 0);
    bus_start();
    send_byte(8'hF2, a);
    chk("R9 ack again", a, 0);
    sw_read(d); pulse_irq_clr();
    pulse_addr(8'hC3);
    send_byte(8'hC4, a);
    chk("R10 nack lo", a, 1); chk("R10 no hold", scl_oe, 0);
    chk("R10 no upd", upd_addr, 0); chk("R10 no irq", irq, 0);
    chk("R10 no load", buf_full, 0);
    bus_stop();
    pulse_addr(8'hF2);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    t_reset();
    t_seven_bit();
    t_mismatch();
    t_overflow();
    t_deferred();
    t_ten_bit();
    t_ten_bit_bad();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R1: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule